// File: doc/BRIEF.md
# Shared-Memory Endpoint Configuration Register File

This block holds the type-0 configuration header of a virtual shared-memory PCI endpoint. A host-side agent issues single-cycle read or write requests of 1, 2 or 4 bytes at a byte address. The response comes back on the next cycle. Each response carries read data and a reject flag.

Only a few fields take written data: two command bits, the BAR address bits above each BAR's size, and the MSI-X enable and function-mask bits. Everything else reads back fixed values or values latched at reset. The latched values are the identity words, the capability layout, and the 64-bit base and size of the shared memory region. A narrow write is first merged into its 32-bit row and then filtered like a full-word write.

The command bits, both BAR bases and the MSI-X control bits leave the block as plain outputs. A one-cycle strobe marks any real change of the bits that decide whether interrupts may be sent.

Top module: `vpci_cfg_space`

## Requirements
- R1: An access is rejected when size is not 1, 2 or 4, or when addr+size exceeds 0x5C. A rejected read returns 0xFFFFFFFF with reject high. A rejected write changes no register and returns reject high with rdata 0.
- R2: Identity fields are read-only:
  - rows 0x00 and 0x2C read 0x11101AF4 (device 0x1110 in the upper half, vendor 0x1AF4 in the lower half);
  - byte 0x0B reads class 0x05;
  - the status half at 0x06 reads 0x0010;
  - byte 0x34 reads the capability offset 0x50.
- R3: In the command half at 0x04, only bit 2 (bus master) and bit 1 (memory enable) take written values. All other command and status bits ignore writes.
- R4: A low BAR dword write stores the value with the bits below the BAR size and bits 3:0 cleared, then sets bit 2 (64-bit type). The BAR at 0x10 spans 256 bytes and the BAR at 0x20 spans 16 bytes. The dwords at 0x18 and 0x1C always read 0.
- R5: The high BAR dwords at 0x14 and 0x24 store every written bit.
- R6: The MSI-X word at 0x50 resets to 0xC0000011. Only bit 31 (enable) and bit 30 (function mask) are writable. The word at 0x54 reads 0x4 and the word at 0x58 reads 0x14.
- R7: The 64-bit shared-memory base at 0x40 and size at 0x48 load from shm_base_in and shm_size_in during reset. They ignore writes.
- R8: A 1- or 2-byte write replaces only its own byte lanes of the current row. The merged row is then filtered as a 4-byte write.
- R9: A 1- or 2-byte read returns the row at addr[7:2] shifted right by 8*addr[1:0] and truncated to the access width. A 4-byte access uses the row at addr[7:2].
- R10: Each response appears on the cycle after the request. An accepted write returns rdata 0 with reject low.
- R11: ctrl_changed pulses together with the response exactly when cmd_master, msix_en or msix_fm changes value.
- R12: After reset, both command bits and all BAR dwords are 0, and msix_en and msix_fm are 1.
- R13: bar0_base is the 0x14 row above the 0x10 row, with bits 3:0 forced to 0. bar2_base is built the same way from rows 0x24 and 0x20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Request valid for this cycle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 8 | Byte address in configuration space |
| size | input | 3 | Access width in bytes (1, 2 or 4) |
| wdata | input | 32 | Write data, lane 0 aligned |
| shm_base_in | input | 64 | Shared-memory base loaded at reset |
| shm_size_in | input | 64 | Shared-memory size loaded at reset |
| rdata | output | 32 | Read data of the previous request |
| reject | output | 1 | Previous request was rejected |
| ctrl_changed | output | 1 | Interrupt-gating bits changed on the previous request |
| cmd_master | output | 1 | Bus-master bit |
| cmd_mem | output | 1 | Memory-space enable bit |
| msix_en | output | 1 | MSI-X enable bit |
| msix_fm | output | 1 | MSI-X function-mask bit |
| bar0_base | output | 64 | Register BAR base address |
| bar2_base | output | 64 | MSI-X table BAR base address |

## Verification
Every response is registered once, so rdata, reject and ctrl_changed belong to the request captured on the previous rising edge. The register outputs change on that same edge. The driver raises req at a falling edge and files the expected response in a queue. The monitor sees req high at the next rising edge, waits one time unit past that edge, and then pops and compares the entry. The exported bits and bases are compared at the falling edge after the driving request has completed.

// File: rtl/vpci_cfg_pkg.sv
package vpci_cfg_pkg;

    localparam int unsigned CMD_MEM_BIT    = 1;
    localparam int unsigned CMD_MASTER_BIT = 2;
    localparam int unsigned MSIX_EN_BIT    = 31;
    localparam int unsigned MSIX_FM_BIT    = 30;
    localparam int unsigned BAR_DWORDS     = 6;

    typedef struct packed {
        logic                        cmd_master;
        logic                        cmd_mem;
        logic                        msix_en;
        logic                        msix_fm;
        logic [BAR_DWORDS-1:0][31:0] bar_row;
        logic [63:0]                 shm_base;
        logic [63:0]                 shm_size;
        logic [31:0]                 rdata;
        logic                        rsp_reject;
        logic                        ctrl_chg;
    } cfg_state_t;

endpackage

// File: rtl/vpci_lane_merge.sv
module vpci_lane_merge #(
    parameter int unsigned DW = 32
) (
    input  logic [DW-1:0] row_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [2:0]    size_i,
    input  logic [1:0]    ofs_i,
    output logic [DW-1:0] row_o
);
    logic [DW-1:0] lane_mask;
    logic [DW-1:0] mask_sh;
    logic [DW-1:0] data_sh;

    always_comb begin
        case (size_i)
            3'd1:    lane_mask = DW'(8'hFF);
            3'd2:    lane_mask = DW'(16'hFFFF);
            default: lane_mask = '1;
        endcase
        mask_sh = lane_mask << {ofs_i, 3'b000};
        data_sh = (wdata_i & lane_mask) << {ofs_i, 3'b000};
        row_o   = (row_i & ~mask_sh) | (data_sh & mask_sh);
    end
endmodule

// File: rtl/vpci_read_align.sv
module vpci_read_align #(
    parameter int unsigned DW = 32
) (
    input  logic [DW-1:0] row_i,
    input  logic [2:0]    size_i,
    input  logic [1:0]    ofs_i,
    output logic [DW-1:0] data_o
);
    logic [DW-1:0] lane_mask;

    always_comb begin
        case (size_i)
            3'd1:    lane_mask = DW'(8'hFF);
            3'd2:    lane_mask = DW'(16'hFFFF);
            default: lane_mask = '1;
        endcase
        data_o = (row_i >> {ofs_i, 3'b000}) & lane_mask;
    end
endmodule

// File: rtl/vpci_bar_filter.sv
module vpci_bar_filter #(
    parameter longint unsigned BYTES = 256,
    parameter logic [3:0]      FLAGS = 4'h4
) (
    input  logic [31:0] val_i,
    input  logic        is_hi_i,
    output logic [31:0] val_o
);
    localparam logic [63:0] KEEP = ~(64'(BYTES) - 64'd1);

    always_comb begin
        if (is_hi_i)
            val_o = val_i & KEEP[63:32];
        else
            val_o = (val_i & KEEP[31:0] & ~32'hF) | {28'h0, FLAGS};
    end
endmodule

// File: rtl/vpci_cfg_space.sv
module vpci_cfg_space
    import vpci_cfg_pkg::*;
#(
    parameter logic [15:0]     VENDOR_ID  = 16'h1AF4,
    parameter logic [15:0]     DEVICE_ID  = 16'h1110,
    parameter logic [7:0]      CLASS_CODE = 8'h05,
    parameter logic [7:0]      CAP_OFS    = 8'h50,
    parameter int unsigned     CFG_BYTES  = 92,
    parameter longint unsigned BAR0_BYTES = 256,
    parameter longint unsigned BAR2_BYTES = 16,
    parameter logic [7:0]      PBA_OFS    = 8'h10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req,
    input  logic        we,
    input  logic [7:0]  addr,
    input  logic [2:0]  size,
    input  logic [31:0] wdata,
    input  logic [63:0] shm_base_in,
    input  logic [63:0] shm_size_in,
    output logic [31:0] rdata,
    output logic        reject,
    output logic        ctrl_changed,
    output logic        cmd_master,
    output logic        cmd_mem,
    output logic        msix_en,
    output logic        msix_fm,
    output logic [63:0] bar0_base,
    output logic [63:0] bar2_base
);
    localparam logic [5:0] ROW_ID     = 6'd0;
    localparam logic [5:0] ROW_CMD    = 6'd1;
    localparam logic [5:0] ROW_CLASS  = 6'd2;
    localparam logic [5:0] BAR_LO_ROW = 6'd4;
    localparam logic [5:0] BAR_HI_ROW = BAR_LO_ROW + 6'(BAR_DWORDS) - 6'd1;
    localparam logic [5:0] ROW_SUBSYS = 6'd11;
    localparam logic [5:0] ROW_CAPPTR = 6'd13;
    localparam logic [5:0] ROW_SHM    = 6'd16;
    localparam logic [5:0] ROW_CAP    = 6'(CAP_OFS >> 2);
    localparam logic [31:0] ID_WORD   = {DEVICE_ID, VENDOR_ID};
    localparam logic [31:0] TBL_WORD  = 32'h4;
    localparam logic [31:0] PBA_WORD  = {24'h0, PBA_OFS} | 32'h4;
    localparam int unsigned NUM_BARS  = BAR_DWORDS / 2;

    cfg_state_t cur_q, nxt_d, rst_d;

    logic [5:0]  row_idx;
    logic [1:0]  eff_ofs;
    logic [8:0]  acc_end;
    logic        acc_bad;
    logic [31:0] row_rd;
    logic [31:0] row_merged;
    logic [31:0] rd_aligned;
    logic [2:0]  bar_slot;
    logic [31:0] bar_filt [NUM_BARS];

    assign row_idx = addr[7:2];
    assign eff_ofs = (size == 3'd4) ? 2'd0 : addr[1:0];
    assign acc_end = {1'b0, addr} + {6'b0, size};
    assign acc_bad = !(size == 3'd1 || size == 3'd2 || size == 3'd4)
                     || (acc_end > 9'(CFG_BYTES));
    assign bar_slot = 3'(row_idx - BAR_LO_ROW);

    always_comb begin
        row_rd = '0;
        if (row_idx >= BAR_LO_ROW && row_idx <= BAR_HI_ROW) begin
            row_rd = cur_q.bar_row[bar_slot];
        end else begin
            case (row_idx)
                ROW_ID, ROW_SUBSYS: row_rd = ID_WORD;
                ROW_CMD:    row_rd = {16'h0010, 13'h0, cur_q.cmd_master, cur_q.cmd_mem, 1'b0};
                ROW_CLASS:  row_rd = {CLASS_CODE, 24'h0};
                ROW_CAPPTR: row_rd = {24'h0, CAP_OFS};
                ROW_SHM:          row_rd = cur_q.shm_base[31:0];
                ROW_SHM + 6'd1:   row_rd = cur_q.shm_base[63:32];
                ROW_SHM + 6'd2:   row_rd = cur_q.shm_size[31:0];
                ROW_SHM + 6'd3:   row_rd = cur_q.shm_size[63:32];
                ROW_CAP:          row_rd = {cur_q.msix_en, cur_q.msix_fm, 14'h0, 8'h00, 8'h11};
                ROW_CAP + 6'd1:   row_rd = TBL_WORD;
                ROW_CAP + 6'd2:   row_rd = PBA_WORD;
                default:          row_rd = '0;
            endcase
        end
    end

    vpci_lane_merge #(.DW(32)) u_merge (
        .row_i   (row_rd),
        .wdata_i (wdata),
        .size_i  (size),
        .ofs_i   (eff_ofs),
        .row_o   (row_merged)
    );

    vpci_read_align #(.DW(32)) u_align (
        .row_i  (row_rd),
        .size_i (size),
        .ofs_i  (eff_ofs),
        .data_o (rd_aligned)
    );

    for (genvar g = 0; g < NUM_BARS; g++) begin : g_bar
        localparam longint unsigned SZ = (g == 0) ? BAR0_BYTES :
                                         (g == NUM_BARS - 1) ? BAR2_BYTES : 64'd0;
        localparam logic [3:0] FL = (SZ == 0) ? 4'h0 : 4'h4;
        vpci_bar_filter #(.BYTES(SZ), .FLAGS(FL)) u_filt (
            .val_i   (row_merged),
            .is_hi_i (row_idx[0]),
            .val_o   (bar_filt[g])
        );
    end

    always_comb begin
        rst_d            = '0;
        rst_d.msix_en    = 1'b1;
        rst_d.msix_fm    = 1'b1;
        rst_d.shm_base   = shm_base_in;
        rst_d.shm_size   = shm_size_in;
    end

    always_comb begin
        nxt_d            = cur_q;
        nxt_d.rdata      = '0;
        nxt_d.rsp_reject = 1'b0;
        if (req) begin
            if (acc_bad) begin
                nxt_d.rsp_reject = 1'b1;
                nxt_d.rdata      = we ? '0 : '1;
            end else if (!we) begin
                nxt_d.rdata = rd_aligned;
            end else begin
                if (row_idx == ROW_CMD) begin
                    nxt_d.cmd_mem    = row_merged[CMD_MEM_BIT];
                    nxt_d.cmd_master = row_merged[CMD_MASTER_BIT];
                end
                if (row_idx >= BAR_LO_ROW && row_idx <= BAR_HI_ROW)
                    nxt_d.bar_row[bar_slot] = bar_filt[bar_slot[2:1]];
                if (row_idx == ROW_CAP) begin
                    nxt_d.msix_en = row_merged[MSIX_EN_BIT];
                    nxt_d.msix_fm = row_merged[MSIX_FM_BIT];
                end
            end
        end
        nxt_d.ctrl_chg = (nxt_d.cmd_master != cur_q.cmd_master)
                       | (nxt_d.msix_en != cur_q.msix_en)
                       | (nxt_d.msix_fm != cur_q.msix_fm);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= rst_d;
        else        cur_q <= nxt_d;
    end

    assign rdata        = cur_q.rdata;
    assign reject       = cur_q.rsp_reject;
    assign ctrl_changed = cur_q.ctrl_chg;
    assign cmd_master   = cur_q.cmd_master;
    assign cmd_mem      = cur_q.cmd_mem;
    assign msix_en      = cur_q.msix_en;
    assign msix_fm      = cur_q.msix_fm;
    assign bar0_base    = {cur_q.bar_row[1], cur_q.bar_row[0][31:4], 4'h0};
    assign bar2_base    = {cur_q.bar_row[BAR_DWORDS-1], cur_q.bar_row[BAR_DWORDS-2][31:4], 4'h0};
endmodule

// File: rtl/vpci_cfg_space_chk.sv
module vpci_cfg_space_chk #(
    parameter int unsigned CFG_BYTES = 92
) (
    input logic        clk,
    input logic        rst_n,
    input logic        req,
    input logic        we,
    input logic [7:0]  addr,
    input logic [2:0]  size,
    input logic [31:0] rdata,
    input logic        reject,
    input logic        ctrl_changed,
    input logic        cmd_master,
    input logic        cmd_mem,
    input logic        msix_en,
    input logic        msix_fm,
    input logic [63:0] bar0_base,
    input logic [63:0] bar2_base
);
    logic over_end;
    assign over_end = ({1'b0, addr} + {6'b0, size}) > 9'(CFG_BYTES);

    AST_REJECT_READ_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        req && !we && over_end |=> reject && rdata == 32'hFFFF_FFFF); // R1

    AST_REJECT_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        req && we && over_end |=> reject && $stable(cmd_master) && $stable(cmd_mem)
        && $stable(msix_en) && $stable(msix_fm) && $stable(bar0_base) && $stable(bar2_base)); // R1

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(req && we) |=> $stable(cmd_master) && $stable(cmd_mem) && $stable(msix_en)
        && $stable(msix_fm) && $stable(bar0_base) && $stable(bar2_base)); // R10

    AST_ID_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        req && !we && addr == 8'h00 && size == 3'd4 |=> !reject && rdata == 32'h1110_1AF4); // R2

    AST_STROBE_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_master != $past(cmd_master)) || (msix_en != $past(msix_en))
        || (msix_fm != $past(msix_fm)) |-> ctrl_changed); // R11

    AST_STROBE_ONLY_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_changed |-> (cmd_master != $past(cmd_master)) || (msix_en != $past(msix_en))
        || (msix_fm != $past(msix_fm))); // R11
endmodule

bind vpci_cfg_space vpci_cfg_space_chk u_chk (.*);

// File: tb/vpci_cfg_space_bench.sv
module vpci_cfg_space_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [7:0]  addr = '0;
    logic [2:0]  size = 3'd4;
    logic [31:0] wdata = '0;
    logic [63:0] shm_base_in = 64'h1234_5678_9ABC_DEF0;
    logic [63:0] shm_size_in = 64'h0000_0000_0010_0000;
    logic [31:0] rdata;
    logic        reject, ctrl_changed, cmd_master, cmd_mem, msix_en, msix_fm;
    logic [63:0] bar0_base, bar2_base;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] rd;
        logic        rej;
        logic        chg;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;

    vpci_cfg_space u_vpci_cfg_space (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .size(size),
        .wdata(wdata), .shm_base_in(shm_base_in), .shm_size_in(shm_size_in),
        .rdata(rdata), .reject(reject), .ctrl_changed(ctrl_changed),
        .cmd_master(cmd_master), .cmd_mem(cmd_mem), .msix_en(msix_en),
        .msix_fm(msix_fm), .bar0_base(bar0_base), .bar2_base(bar2_base)
    );

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic xact(input logic w, input logic [7:0] a, input logic [2:0] s,
                        input logic [31:0] d, input logic [31:0] erd,
                        input logic erej, input logic echg, input string tag);
        exp_t e;
        @(negedge clk);
        req = 1'b1; we = w; addr = a; size = s; wdata = d;
        e.rd = erd; e.rej = erej; e.chg = echg; e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
        req = 1'b0; we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [2:0] s, input logic [31:0] erd, input string tag);
        xact(1'b0, a, s, 32'h0, erd, 1'b0, 1'b0, tag);
    endtask

    task automatic wr(input logic [7:0] a, input logic [2:0] s, input logic [31:0] d,
                      input logic echg, input string tag);
        xact(1'b1, a, s, d, 32'h0, 1'b0, echg, tag);
    endtask

    // monitor: response due one cycle after the request edge
    always @(posedge clk) begin
        if (req === 1'b1 && rst_n === 1'b1) begin
            exp_t e;
            #1;
            if (sb.size() == 0) begin
                checks++; errors++;
                $display("FAIL R10 actual response expected none queued");
            end else begin
                e = sb.pop_front();
                chk({32'h0, rdata}, {32'h0, e.rd}, {e.tag, " rdata"});
                chk({63'h0, reject}, {63'h0, e.rej}, {e.tag, " reject"});
                chk({63'h0, ctrl_changed}, {63'h0, e.chg}, {e.tag, " R11 ctrl_changed"});
            end
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk({63'h0, cmd_master}, 64'h0, "R12 cmd_master");
        chk({63'h0, cmd_mem}, 64'h0, "R12 cmd_mem");
        chk({63'h0, msix_en}, 64'h1, "R12 msix_en");
        chk({63'h0, msix_fm}, 64'h1, "R12 msix_fm");
        chk(bar0_base, 64'h0, "R12 bar0_base");
        chk({63'h0, ctrl_changed}, 64'h0, "R12 ctrl_changed");

        // R2 identity
        rd(8'h00, 3'd4, 32'h1110_1AF4, "R2 id");
        rd(8'h2C, 3'd4, 32'h1110_1AF4, "R2 subsys");
        rd(8'h0B, 3'd1, 32'h05, "R2 class");
        rd(8'h06, 3'd2, 32'h0010, "R2 status");
        rd(8'h34, 3'd1, 32'h50, "R2 capptr");
        wr(8'h00, 3'd4, 32'h0, 1'b0, "R2 id write");
        rd(8'h00, 3'd4, 32'h1110_1AF4, "R2 id after write");
        // R9 narrow reads
        rd(8'h02, 3'd2, 32'h1110, "R9 upper half");
        rd(8'h01, 3'd2, 32'h101A, "R9 offset1 half");
        rd(8'h03, 3'd2, 32'h11, "R9 offset3 half");
        rd(8'h01, 3'd4, 32'h1110_1AF4, "R9 word uses row");

        // R7 shared memory fields
        rd(8'h40, 3'd4, 32'h9ABC_DEF0, "R7 base lo");
        rd(8'h44, 3'd4, 32'h1234_5678, "R7 base hi");
        rd(8'h48, 3'd4, 32'h0010_0000, "R7 size lo");
        rd(8'h4C, 3'd4, 32'h0, "R7 size hi");
        wr(8'h40, 3'd4, 32'hFFFF_FFFF, 1'b0, "R7 write");
        rd(8'h40, 3'd4, 32'h9ABC_DEF0, "R7 base after write");

        // R3 command
        wr(8'h04, 3'd4, 32'hFFFF_FFFF, 1'b1, "R3 cmd all ones");
        rd(8'h04, 3'd4, 32'h0010_0006, "R3 cmd readback");
        chk({62'h0, cmd_master, cmd_mem}, 64'h3, "R3 cmd outputs");
        wr(8'h04, 3'd2, 32'h0004, 1'b0, "R3 clear mem");
        rd(8'h04, 3'd4, 32'h0010_0004, "R3 after clear mem");
        wr(8'h06, 3'd2, 32'hFFFF, 1'b0, "R8 status write");
        rd(8'h04, 3'd4, 32'h0010_0004, "R8 status lane kept cmd");

        // R4 R5 BARs
        wr(8'h10, 3'd4, 32'hFFFF_FFFF, 1'b0, "R4 bar0 lo");
        rd(8'h10, 3'd4, 32'hFFFF_FF04, "R4 bar0 lo read");
        wr(8'h14, 3'd4, 32'hFFFF_FFFF, 1'b0, "R5 bar0 hi");
        rd(8'h14, 3'd4, 32'hFFFF_FFFF, "R5 bar0 hi read");
        wr(8'h10, 3'd4, 32'hDEAD_BEEF, 1'b0, "R4 bar0 lo pattern");
        rd(8'h10, 3'd4, 32'hDEAD_BE04, "R4 bar0 pattern read");
        wr(8'h12, 3'd2, 32'h1234, 1'b0, "R8 bar0 half write");
        rd(8'h10, 3'd2, 32'hBE04, "R8 bar0 low half");
        rd(8'h12, 3'd2, 32'h1234, "R8 bar0 high half");
        chk(bar0_base, 64'hFFFF_FFFF_1234_BE00, "R13 bar0_base");
        wr(8'h18, 3'd4, 32'hFFFF_FFFF, 1'b0, "R4 empty bar lo");
        rd(8'h18, 3'd4, 32'h0, "R4 empty bar lo read");
        wr(8'h1C, 3'd4, 32'hFFFF_FFFF, 1'b0, "R4 empty bar hi");
        rd(8'h1C, 3'd4, 32'h0, "R4 empty bar hi read");
        wr(8'h20, 3'd4, 32'h1234_5678, 1'b0, "R4 bar2 lo");
        rd(8'h20, 3'd4, 32'h1234_5674, "R4 bar2 lo read");
        wr(8'h24, 3'd4, 32'h0000_ABCD, 1'b0, "R5 bar2 hi");
        rd(8'h24, 3'd4, 32'h0000_ABCD, "R5 bar2 hi read");
        chk(bar2_base, 64'h0000_ABCD_1234_5670, "R13 bar2_base");

        // R6 MSI-X
        rd(8'h50, 3'd4, 32'hC000_0011, "R6 cap reset");
        rd(8'h54, 3'd4, 32'h4, "R6 table word");
        rd(8'h58, 3'd4, 32'h14, "R6 pba word");
        wr(8'h50, 3'd4, 32'h0000_FFFF, 1'b1, "R6 clear en fm");
        rd(8'h50, 3'd4, 32'h0000_0011, "R6 after clear");
        chk({62'h0, msix_en, msix_fm}, 64'h0, "R6 outputs cleared");
        wr(8'h53, 3'd1, 32'h80, 1'b1, "R8 byte enable");
        rd(8'h53, 3'd1, 32'h80, "R9 byte read");
        rd(8'h50, 3'd4, 32'h8000_0011, "R8 cap merged");
        wr(8'h53, 3'd1, 32'h80, 1'b0, "R11 same value no strobe");
        wr(8'h04, 3'd4, 32'h0, 1'b1, "R11 master drop");
        chk({63'h0, cmd_master}, 64'h0, "R11 master low");

        // R1 rejects
        xact(1'b0, 8'h5A, 3'd4, 32'h0, 32'hFFFF_FFFF, 1'b1, 1'b0, "R1 read past end");
        rd(8'h5B, 3'd1, 32'h0, "R1 last byte ok");
        rd(8'h58, 3'd4, 32'h14, "R1 last word ok");
        xact(1'b0, 8'h5C, 3'd1, 32'h0, 32'hFFFF_FFFF, 1'b1, 1'b0, "R1 byte at end");
        xact(1'b0, 8'h00, 3'd3, 32'h0, 32'hFFFF_FFFF, 1'b1, 1'b0, "R1 bad size read");
        xact(1'b1, 8'h50, 3'd3, 32'h0, 32'h0, 1'b1, 1'b0, "R1 bad size write");
        rd(8'h50, 3'd4, 32'h8000_0011, "R1 cap unchanged");
        xact(1'b1, 8'h5A, 3'd4, 32'hFFFF_FFFF, 32'h0, 1'b1, 1'b0, "R1 write past end");

        repeat (3) @(negedge clk);
        chk({32'h0, 32'(sb.size())}, 64'h0, "R10 queue drained");
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule